// File: doc/BRIEF.md
# Contactless Tag Command and Memory Controller

This block is the digital core of a short-range contactless memory tag. It receives request frames that have already been demodulated into bytes, checks their CRC-B trailer, decodes the command and steps the tag through its selection states: idle after reset, woken, selected, put aside, and finally retired until the next reset. While it is selected the reader can read any of the sixteen 16-bit blocks and write the user blocks. The first four blocks hold a fixed 64-bit identifier. The last block holds one-time-programmable lock bits and the 4-bit chip identifier.

Replies leave as a byte stream that carries its own CRC-B trailer. A one-cycle flag announces each reply so that the analogue front end can switch to its answer mode. Each lock bit guards a pair of adjacent blocks. A newly set lock bit does not restrict writes until the next matching select. Each executed write makes the block deaf for a programmable busy window, which models the self-timed programming cycle of the memory.

Top module: `tag_ctrl`

## Requirements
- R1: After reset the tag is idle and nothing is sent. In this idle state every frame except the wake command (bytes 06h 00h) is ignored and gets no reply.
- R2: In the idle state the wake command moves the tag to the woken state. The reply is the chip ID byte, which is 0000b over the 4-bit CHIP_ID. A later wake command is ignored.
- R3: The select command (0Eh, then an ID byte) is obeyed in the woken, selected and put-aside states. Only bits 3:0 of the ID byte are compared. On a match the tag becomes selected and replies with the chip ID byte. On a mismatch it becomes put aside and sends no reply.
- R4: When the tag is selected, a read (08h, then an address byte with the block number in bits 3:0) returns the block's low byte and then its high byte. Block k for k from 0 to 3 holds UID bits 16k+15 down to 16k.
- R5: When the tag is selected, a write (09h, address, low byte, high byte) to an unlocked block from 4 to 14 stores the data and sends no reply. A write to blocks 0 to 3 has no effect.
- R6: Each executed write starts a busy window of WR_BUSY_CYCLES cycles. Any frame that arrives during the window is ignored.
- R7: Block 15 reads as the lock byte in bits 15:8 and as 0000b over CHIP_ID in bits 7:0, so a read of block 15 returns the chip ID byte first. A write to block 15 ORs its high byte into the lock byte. Lock bits are never cleared.
- R8: Lock bit k blocks writes to blocks 2k and 2k+1. This takes effect only after the next matching select copies the lock byte into the write-permission logic.
- R9: When the tag is selected, the completion command (0Fh alone) retires the tag and sends no reply. After that every frame is ignored until reset. In any other state the completion command is ignored.
- R10: Replies end with a CRC-B over the payload: the reflected polynomial x^16+x^12+x^5+1, a start value of FFFFh and a final inversion, sent low byte first. A request whose CRC-B check fails is discarded with no reply.
- R11: A frame whose total length, CRC included, does not fit its opcode is ignored and leaves the state unchanged. The required lengths are: wake 4, select 4, completion 3, read 4, write 6.
- R12: Read, write and completion commands are ignored in every state except selected.
- R13: Each reply is announced by a one-cycle pulse on resp_req. The first reply byte follows two cycles later. After that one byte is sent per cycle, and tx_last marks the final byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also the power-on event |
| rx_start | input | 1 | Start-of-frame marker; clears the receive buffer |
| rx_valid | input | 1 | rx_data carries one request byte |
| rx_data | input | 8 | Request byte |
| rx_end | input | 1 | End-of-frame marker |
| tx_valid | output | 1 | tx_data carries one reply byte |
| tx_data | output | 8 | Reply byte |
| tx_last | output | 1 | Final byte of the reply |
| resp_req | output | 1 | Pulse announcing that a reply follows |

## Verification
The assertions assume that a frame arrives as a start marker, then its bytes, then an end marker, and that the markers never fall in the same cycle as a byte. They also assume that no new frame ends while a reply is being announced or sent. The bench drives every frame in that order, one byte per cycle. After each frame it waits long enough for the longest reply to drain. After each executed write it waits out the busy window, except in the one test that deliberately sends a frame inside the window.

// File: rtl/tag_pkg.sv
package tag_pkg;
    localparam int BLK_W     = 16;
    localparam int NBLK      = 16;
    localparam int ADDR_W    = $clog2(NBLK);
    localparam int UID_BLKS  = 4;
    localparam int USER_BLKS = NBLK - UID_BLKS - 1;

    localparam logic [15:0] CRC_SEED  = 16'hFFFF;
    localparam logic [15:0] CRC_GOOD  = 16'hF0B8;  // residue after data plus trailer
    localparam logic [15:0] CRC_POLYR = 16'h8408;

    localparam logic [7:0] OP_WAKE = 8'h06;
    localparam logic [7:0] OP_SEL  = 8'h0E;
    localparam logic [7:0] OP_DONE = 8'h0F;
    localparam logic [7:0] OP_RD   = 8'h08;
    localparam logic [7:0] OP_WR   = 8'h09;

    typedef enum logic [2:0] {
        ST_IDLE, ST_AWAKE, ST_SEL, ST_ASIDE, ST_RETIRED
    } tag_state_e;

    function automatic logic [15:0] crc_byte(logic [15:0] c, logic [7:0] b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int i = 0; i < 8; i++)
            r = r[0] ? ((r >> 1) ^ CRC_POLYR) : (r >> 1);
        return r;
    endfunction
endpackage

// File: rtl/tag_rx.sv
module tag_rx
    import tag_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int KEEP_N = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_start,
    input  logic                   rx_valid,
    input  logic [7:0]             rx_data,
    input  logic                   rx_end,
    output logic                   frm_vld,
    output logic [CNT_W-1:0]       frm_len,
    output logic                   frm_crc_ok,
    output logic [KEEP_N-1:0][7:0] frm_bytes
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0]       cnt;
        logic [15:0]            crc;
        logic [KEEP_N-1:0][7:0] b;
        logic                   vld;
    } rx_s;

    rx_s q, d;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        if (rx_start) begin
            d.cnt = '0;
            d.crc = CRC_SEED;
        end else if (rx_valid) begin
            for (int i = 0; i < KEEP_N; i++)
                if (q.cnt == CNT_W'(i)) d.b[i] = rx_data;
            if (q.cnt != CNT_MAX) d.cnt = q.cnt + 1'b1;
            d.crc = crc_byte(q.crc, rx_data);
        end
        if (rx_end) d.vld = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.crc <= CRC_SEED;
        end else begin
            q <= d;
        end
    end

    assign frm_vld    = q.vld;
    assign frm_len    = q.cnt;
    assign frm_crc_ok = (q.crc == CRC_GOOD);
    assign frm_bytes  = q.b;
endmodule

// File: rtl/tag_tx.sv
module tag_tx
    import tag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       two,
    input  logic [7:0] p0,
    input  logic [7:0] p1,
    output logic       busy,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       tx_last
);
    typedef struct packed {
        logic [3:0][7:0] buf_b;
        logic [1:0]      idx;
        logic [1:0]      end_idx;
        logic            act;
        logic            vld;
        logic [7:0]      dat;
        logic            lst;
    } tx_s;

    tx_s q, d;
    logic [15:0] c;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        d.lst = 1'b0;
        c     = crc_byte(CRC_SEED, p0);
        if (two) c = crc_byte(c, p1);
        c = ~c;
        if (start) begin
            d.buf_b   = two ? {c[15:8], c[7:0], p1, p0} : {8'h00, c[15:8], c[7:0], p0};
            d.idx     = 2'd0;
            d.end_idx = two ? 2'd3 : 2'd2;
            d.act     = 1'b1;
        end else if (q.act) begin
            d.vld = 1'b1;
            d.dat = q.buf_b[q.idx];
            d.lst = (q.idx == q.end_idx);
            if (q.idx == q.end_idx) d.act = 1'b0;
            else                    d.idx = q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = q.act;
    assign tx_valid = q.vld;
    assign tx_data  = q.dat;
    assign tx_last  = q.lst;

    p_last_has_valid_r13: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);
    p_no_restart_r13: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/tag_ctrl.sv
module tag_ctrl
    import tag_pkg::*;
#(
    parameter logic [3:0]  CHIP_ID        = 4'h5,
    parameter logic [63:0] UID            = 64'hA1B2_C3D4_E5F6_0718,
    parameter int          WR_BUSY_CYCLES = 250000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_start,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_end,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       tx_last,
    output logic       resp_req
);
    localparam int CNT_W  = 4;
    localparam int BUSY_W = $clog2(WR_BUSY_CYCLES + 1);

    logic                   frm_vld, frm_crc_ok, tx_busy;
    logic [CNT_W-1:0]       frm_len;
    logic [3:0][7:0]        fb;

    tag_rx #(.CNT_W(CNT_W), .KEEP_N(4)) u_rx (
        .clk, .rst_n, .rx_start, .rx_valid, .rx_data, .rx_end,
        .frm_vld, .frm_len, .frm_crc_ok, .frm_bytes(fb)
    );

    typedef struct packed {
        tag_state_e                     st;
        logic [USER_BLKS-1:0][BLK_W-1:0] user;
        logic [7:0]                     lock;
        logic [7:0]                     lock_act;
        logic [BUSY_W-1:0]              busy_cnt;
        logic                           go;
        logic                           two;
        logic [7:0]                     p0;
        logic [7:0]                     p1;
    } ctl_s;

    ctl_s q, d;
    logic             accept;
    logic [ADDR_W-1:0] a;
    logic [BLK_W-1:0] rd;

    always_comb begin
        d      = q;
        d.go   = 1'b0;
        a      = fb[1][ADDR_W-1:0];
        if (q.busy_cnt != '0) d.busy_cnt = q.busy_cnt - 1'b1;
        if (a < ADDR_W'(UID_BLKS))       rd = UID[a*BLK_W +: BLK_W];
        else if (a == ADDR_W'(NBLK - 1)) rd = {q.lock, 4'h0, CHIP_ID};
        else                             rd = q.user[ADDR_W'(a - ADDR_W'(UID_BLKS))];
        accept = frm_vld && frm_crc_ok && (q.busy_cnt == '0) && !tx_busy && !q.go;
        if (accept) begin
            unique case (fb[0])
                OP_WAKE: if (frm_len == 4 && fb[1] == 8'h00 && q.st == ST_IDLE) begin
                    d.st  = ST_AWAKE;
                    d.go  = 1'b1;
                    d.two = 1'b0;
                    d.p0  = {4'h0, CHIP_ID};
                end
                OP_SEL: if (frm_len == 4 && q.st inside {ST_AWAKE, ST_SEL, ST_ASIDE}) begin
                    if (fb[1][3:0] == CHIP_ID) begin
                        d.st       = ST_SEL;
                        d.lock_act = q.lock;
                        d.go       = 1'b1;
                        d.two      = 1'b0;
                        d.p0       = {4'h0, CHIP_ID};
                    end else begin
                        d.st = ST_ASIDE;
                    end
                end
                OP_DONE: if (frm_len == 3 && q.st == ST_SEL) d.st = ST_RETIRED;
                OP_RD: if (frm_len == 4 && q.st == ST_SEL) begin
                    d.go  = 1'b1;
                    d.two = 1'b1;
                    d.p0  = rd[7:0];
                    d.p1  = rd[15:8];
                end
                OP_WR: if (frm_len == 6 && q.st == ST_SEL && a >= ADDR_W'(UID_BLKS)
                           && !q.lock_act[a[ADDR_W-1:1]]) begin
                    if (a == ADDR_W'(NBLK - 1)) d.lock = q.lock | fb[3];
                    else d.user[ADDR_W'(a - ADDR_W'(UID_BLKS))] = {fb[3], fb[2]};
                    d.busy_cnt = BUSY_W'(WR_BUSY_CYCLES);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    tag_tx u_tx (
        .clk, .rst_n, .start(q.go), .two(q.two), .p0(q.p0), .p1(q.p1),
        .busy(tx_busy), .tx_valid, .tx_data, .tx_last
    );

    assign resp_req = q.go;

    logic [7:0] lock_w;
    tag_state_e st_w;
    logic       busy_w;
    assign lock_w = q.lock;
    assign st_w   = q.st;
    assign busy_w = (q.busy_cnt != '0);

    p_lock_only_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lock_w & $past(lock_w)) == $past(lock_w)));
    p_retired_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_w == ST_RETIRED |=> st_w == ST_RETIRED);
    p_bad_crc_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && !frm_crc_ok) |=> !resp_req);
    p_busy_deaf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && busy_w) |=> (!resp_req && $stable(st_w)));
    p_idle_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_w == ST_IDLE |=> (st_w == ST_IDLE || st_w == ST_AWAKE));
endmodule

// File: tb/tag_ctrl_tb.sv
module tag_ctrl_tb;
    localparam logic [3:0]  ID  = 4'h5;
    localparam logic [63:0] UIDV = 64'hA1B2_C3D4_E5F6_0718;
    localparam int          BUSY = 40;

    typedef logic [7:0] bq_t[$];

    logic clk = 1'b0, rst_n = 1'b0;
    logic rx_start = 0, rx_valid = 0, rx_end = 0;
    logic [7:0] rx_data = 0;
    logic tx_valid, tx_last, resp_req;
    logic [7:0] tx_data;

    tag_ctrl #(.CHIP_ID(ID), .UID(UIDV), .WR_BUSY_CYCLES(BUSY)) u_dut (
        .clk, .rst_n, .rx_start, .rx_valid, .rx_data, .rx_end,
        .tx_valid, .tx_data, .tx_last, .resp_req
    );

    always #10 clk = ~clk;

    int errors = 0, checks = 0;
    // reference model: 0 idle, 1 awake, 2 selected, 3 aside, 4 retired
    int mst = 0;
    logic [15:0] mmem [16];
    logic [7:0]  mlock = 0, mact = 0;
    bit mbusy = 0;
    logic [7:0] exp_q[$];
    bit         lst_q[$];
    string cur_tag = "R1";

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc16(bq_t v);
        logic [15:0] c = 16'hFFFF;
        foreach (v[k])
            for (int i = 0; i < 8; i++) begin
                logic fbk;
                fbk = c[0] ^ v[k][i];
                c = c >> 1;
                if (fbk) c = c ^ 16'h8408;
            end
        return ~c;
    endfunction

    function automatic void reply(bq_t pl);
        logic [15:0] c = crc16(pl);
        foreach (pl[k]) begin exp_q.push_back(pl[k]); lst_q.push_back(0); end
        exp_q.push_back(c[7:0]);  lst_q.push_back(0);
        exp_q.push_back(c[15:8]); lst_q.push_back(1);
    endfunction

    function automatic logic [15:0] mblk(int a);
        if (a < 4) return UIDV[a*16 +: 16];
        if (a == 15) return {mlock, 4'h0, ID};
        return mmem[a];
    endfunction

    function automatic void model(bq_t pl, bit ok);
        int n = pl.size() + 2;
        int a = pl.size() > 1 ? int'(pl[1][3:0]) : 0;
        logic [15:0] v;
        if (!ok || mbusy) return;
        case (pl[0])
            8'h06: if (n == 4 && pl[1] == 0 && mst == 0) begin mst = 1; reply('{{4'h0, ID}}); end
            8'h0E: if (n == 4 && mst >= 1 && mst <= 3) begin
                if (pl[1][3:0] == ID) begin mst = 2; mact = mlock; reply('{{4'h0, ID}}); end
                else mst = 3;
            end
            8'h0F: if (n == 3 && mst == 2) mst = 4;
            8'h08: if (n == 4 && mst == 2) begin v = mblk(a); reply('{v[7:0], v[15:8]}); end
            8'h09: if (n == 6 && mst == 2 && a >= 4 && !mact[a/2]) begin
                if (a == 15) mlock = mlock | pl[3];
                else mmem[a] = {pl[3], pl[2]};
                mbusy = 1;
            end
            default: ;
        endcase
    endfunction

    // monitor on every clock (R10 byte values, R13 framing)
    bit h1 = 0, h2 = 0, pv = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid && !pv) chk(h2, "R13", "resp_req two cycles before first byte", h2, 1);
            if (tx_valid) begin
                if (exp_q.size() == 0) chk(0, cur_tag, "unexpected reply byte", tx_data, 0);
                else begin
                    logic [7:0] e; bit l;
                    e = exp_q.pop_front(); l = lst_q.pop_front();
                    chk(tx_data == e, cur_tag, "reply byte (R10 trailer)", tx_data, e);
                    chk(tx_last == l, "R13", "tx_last", tx_last, l);
                end
            end
        end
        h2 = h1; h1 = resp_req; pv = tx_valid;
    end

    task automatic send(input bq_t pl, input bit bad, input string tag);
        logic [15:0] c = crc16(pl);
        bq_t fr = pl;
        fr.push_back(c[7:0] ^ (bad ? 8'h01 : 8'h00));
        fr.push_back(c[15:8]);
        cur_tag = tag;
        model(pl, !bad);
        @(negedge clk) rx_start = 1;
        @(negedge clk) rx_start = 0;
        foreach (fr[k]) begin rx_valid = 1; rx_data = fr[k]; @(negedge clk); end
        rx_valid = 0; rx_end = 1;
        @(negedge clk) rx_end = 0;
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, tag, "reply complete", exp_q.size(), 0);
    endtask

    task automatic settle();
        repeat (BUSY + 20) @(negedge clk);
        mbusy = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        foreach (mmem[k]) mmem[k] = 16'h0;
        repeat (3) @(negedge clk);
        chk(tx_valid == 0 && resp_req == 0, "R1", "quiet in reset", tx_valid, 0);
        rst_n = 1;
        @(negedge clk);
        chk(tx_valid == 0 && resp_req == 0, "R1", "quiet after reset", resp_req, 0);
        send('{8'h08, 8'h04}, 0, "R1");
        send('{8'h0E, {4'h0, ID}}, 0, "R1");
        send('{8'h06, 8'h00, 8'h00}, 0, "R11");
        send('{8'h06, 8'h00}, 0, "R2");
        send('{8'h06, 8'h00}, 0, "R2");
        send('{8'h08, 8'h00}, 0, "R12");
        send('{8'h0E, 8'h03}, 0, "R3");
        send('{8'h08, 8'h00}, 0, "R12");
        send('{8'h0F}, 0, "R9");
        send('{8'h0E, 8'hF5}, 0, "R3");
        for (int b = 0; b < 5; b++) send('{8'h08, 8'(b)}, 0, "R4");
        send('{8'h08, 8'h01}, 1, "R10");
        send('{8'h09, 8'h04, 8'hEF, 8'hBE}, 0, "R5"); settle();
        send('{8'h08, 8'h04}, 0, "R5");
        send('{8'h09, 8'h02, 8'h55, 8'hAA}, 0, "R5"); settle();
        send('{8'h08, 8'h02}, 0, "R5");
        send('{8'h09, 8'h0E, 8'h34, 8'h12}, 0, "R5"); settle();
        send('{8'h08, 8'h0E}, 0, "R5");
        send('{8'h09, 8'h05, 8'h34, 8'h12}, 0, "R6");
        send('{8'h08, 8'h05}, 0, "R6");
        send('{8'h09, 8'h06, 8'h99, 8'h99}, 0, "R6");
        settle();
        send('{8'h08, 8'h05}, 0, "R6");
        send('{8'h08, 8'h06}, 0, "R6");
        send('{8'h09, 8'h0F, 8'h00, 8'h04}, 0, "R7"); settle();
        send('{8'h08, 8'h0F}, 0, "R7");
        send('{8'h09, 8'h0F, 8'h00, 8'h00}, 0, "R7"); settle();
        send('{8'h08, 8'h0F}, 0, "R7");
        send('{8'h09, 8'h04, 8'h11, 8'h11}, 0, "R8"); settle();
        send('{8'h08, 8'h04}, 0, "R8");
        send('{8'h0E, {4'h0, ID}}, 0, "R8");
        send('{8'h09, 8'h04, 8'h22, 8'h22}, 0, "R8"); settle();
        send('{8'h08, 8'h04}, 0, "R8");
        send('{8'h09, 8'h06, 8'h33, 8'h33}, 0, "R8"); settle();
        send('{8'h08, 8'h06}, 0, "R8");
        send('{8'h08, 8'h04, 8'h00}, 0, "R11");
        send('{8'h0F}, 0, "R9");
        send('{8'h08, 8'h04}, 0, "R9");
        send('{8'h0E, {4'h0, ID}}, 0, "R9");
        send('{8'h06, 8'h00}, 0, "R9");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule